// File: doc/BRIEF.md
# Irregular-Sequence JK Counter

This block is a three-bit synchronous counter. It does not count in binary. Each enabled rising clock edge moves it one step round the fixed loop 0, 3, 5, 7, 6 and back to 0. Three JK storage cells hold the state. Small excitation logic computes each cell's J and K inputs from the present state only, and all three cells load on the same edge.

Codes 1, 2 and 4 are not part of the loop. Their next states are fixed at 1→3, 2→3 and 4→5, so a corrupted state rejoins the loop on the next enabled edge. When the enable input is low, every cell gets J=K=0 and the state holds. A synchronous active-low reset loads a parameterised start code, which defaults to 0. Setting that parameter to an unused code starts the counter outside the loop, which is how recovery is exercised.

Top module: `irreg_jk_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, the state becomes `RST_STATE` (default 0) at that edge. Reset takes effect only at a clock edge.
- R2: With `rst_n` high and `en` high, the 3-bit `count` output, read as an unsigned number, goes 0→3→5→7→6→0, one step per rising edge.
- R3: With `rst_n` high and `en` low, `count` keeps its value across the edge.
- R4: With `en` high, the unused codes go 1→3, 2→3 and 4→5 in one edge.
- R5: Each storage cell follows the JK rule at a rising edge: J=0,K=0 holds; J=0,K=1 gives 0; J=1,K=0 gives 1; J=1,K=1 inverts.
- R6: Reset takes priority over `en`. When both are active at the same edge, the state becomes `RST_STATE`.
- R7: From any code, at most two enabled edges bring `count` into the set {0,3,5,6,7}. It then stays in that set on every later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Count enable, active high |
| count | output | 3 | Present state, bit 2 is the MSB |

## Verification
The assertions check on every cycle:
- the JK rule in each cell;
- each single step of the loop;
- each step from an unused code;
- holding while disabled;
- the reset load;
- that a loop state never leaves the loop.

Some behaviour is visible only in the bench's scenarios:
- the whole loop repeated over several wraps;
- a reset dropped in the middle of the loop;
- enable toggled between steps;
- recovery from each unused start code, using extra instances reset to 1, 2 and 4.

A behavioural reference model checks all of these against the outputs on every clock.

// File: rtl/jkc_pkg.sv
// Package: shared width and state type for the irregular JK counter.
// Assumes a 3-bit state; the excitation equations are specific to that width.
package jkc_pkg;
    localparam int STATE_W = 3;
    localparam int NUM_CODES = 1 << STATE_W;
    typedef logic [STATE_W-1:0] state_t;
endpackage

// File: rtl/jk_cell.sv
// JK storage cell: one bit of state that updates on the rising clock edge.
// Synchronous active-low reset loads INIT. Assumes j and k are settled before the edge.
module jk_cell #(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic j,
    input  logic k,
    output logic q
);
    // Update the bit according to the JK rule, or load INIT on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= INIT;
        end else begin
            case ({j, k})
                2'b00:   q <= q;
                2'b01:   q <= 1'b0;
                2'b10:   q <= 1'b1;
                default: q <= ~q;
            endcase
        end
    end

    // R5
    jk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!j && !k) |=> (q == $past(q)));
    // R5
    jk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!j && k) |=> (q == 1'b0));
    // R5
    jk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (j && !k) |=> (q == 1'b1));
    // R5
    jk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (j && k) |=> (q != $past(q)));
endmodule

// File: rtl/jkc_excite.sv
// Excitation logic: derives J/K for each bit from the present state.
// The resolved mapping is 0->3->5->7->6->0, with 1->3, 2->3 and 4->5.
// Assumes en low must leave all cells in hold (J=K=0).
module jkc_excite
    import jkc_pkg::*;
(
    input  state_t cur,
    input  logic   en,
    output state_t j,
    output state_t k
);
    state_t j_raw, k_raw;

    // Simplified per-bit equations, derived from the excitation table.
    always_comb begin
        j_raw[0] = ~(cur[2] & cur[1]);
        k_raw[0] =   cur[2] & cur[1];
        j_raw[1] = ~cur[2] | cur[0];
        k_raw[1] =  cur[2] ^ cur[0];
        j_raw[2] =  cur[1] & cur[0];
        k_raw[2] =  cur[1] & ~cur[0];
    end

    // Gate with enable so that a disabled counter holds every bit.
    always_comb begin
        j = en ? j_raw : '0;
        k = en ? k_raw : '0;
    end
endmodule

// File: rtl/irreg_jk_counter.sv
// Top level: a 3-bit counter on the loop 0,3,5,7,6 built from JK cells.
// Synchronous active-low reset loads RST_STATE. en gates the stepping.
// Assumes one clock domain; all cells share one edge.
module irreg_jk_counter
    import jkc_pkg::*;
#(
    parameter logic [2:0] RST_STATE = 3'd0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    output logic [2:0] count
);
    state_t st, jv, kv;

    jkc_excite u_excite (
        .cur (st),
        .en  (en),
        .j   (jv),
        .k   (kv)
    );

    // One JK cell per state bit, each with its own reset value.
    for (genvar b = 0; b < STATE_W; b++) begin : g_bit
        jk_cell #(.INIT(RST_STATE[b])) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .j     (jv[b]),
            .k     (kv[b]),
            .q     (st[b])
        );
    end

    // Drive the output straight from the state.
    always_comb count = st;

    // R1 R6
    reset_load_chk: assert property (@(posedge clk)
        (!rst_n) |=> (count == RST_STATE));
    // R3
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> $stable(count));
    // R2
    step_0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count == 3'd0) |=> (count == 3'd3));
    // R2
    step_3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count == 3'd3) |=> (count == 3'd5));
    // R2
    step_5_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count == 3'd5) |=> (count == 3'd7));
    // R2
    step_7_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count == 3'd7) |=> (count == 3'd6));
    // R2
    step_6_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count == 3'd6) |=> (count == 3'd0));
    // R4
    unused_1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count == 3'd1) |=> (count == 3'd3));
    // R4
    unused_2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count == 3'd2) |=> (count == 3'd3));
    // R4
    unused_4_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && count == 3'd4) |=> (count == 3'd5));
    // R7
    stay_in_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count != 3'd1 && count != 3'd2 && count != 3'd4)
        |=> (count != 3'd1 && count != 3'd2 && count != 3'd4));
endmodule

// File: tb/irreg_jk_counter_tb.sv
module irreg_jk_counter_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic [2:0] c0, c1, c2, c4;
    int checks = 0;
    int errors = 0;
    int model [4];
    int start_code [4] = '{0, 1, 2, 4};
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irreg_jk_counter #(.RST_STATE(3'd0)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .count(c0));
    irreg_jk_counter #(.RST_STATE(3'd1)) u_dut_s1 (
        .clk(clk), .rst_n(rst_n), .en(en), .count(c1));
    irreg_jk_counter #(.RST_STATE(3'd2)) u_dut_s2 (
        .clk(clk), .rst_n(rst_n), .en(en), .count(c2));
    irreg_jk_counter #(.RST_STATE(3'd4)) u_dut_s4 (
        .clk(clk), .rst_n(rst_n), .en(en), .count(c4));

    // Loop and unused-code successors, taken from R2 and R4.
    function automatic int succ(int v);
        int nx [8] = '{3, 3, 3, 5, 5, 7, 0, 6};
        return nx[v];
    endfunction

    function automatic int out_of(int i);
        case (i)
            0: return int'(c0);
            1: return int'(c1);
            2: return int'(c2);
            default: return int'(c4);
        endcase
    endfunction

    task automatic check(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Apply inputs after a falling edge, let the next rising edge act,
    // then compare all four instances at the following falling edge.
    task automatic step(bit r, bit e, string tag);
        rst_n = r;
        en = e;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            if (!r) model[i] = start_code[i];
            else if (e) model[i] = succ(model[i]);
            check(i == 0 ? tag : "R4/R7", out_of(i), model[i]);
        end
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state of each instance
        step(1'b0, 1'b0, "R1");
        step(1'b0, 1'b1, "R6");
        // R4 R7: recovery of the unused codes, then three full wraps (R2)
        for (int n = 0; n < 16; n++) step(1'b1, 1'b1, "R2");
        // R3: hold at several points with the enable toggled
        for (int n = 0; n < 12; n++) step(1'b1, n % 3 == 0, "R3");
        // R6: reset with the enable high in mid-loop
        step(1'b1, 1'b1, "R2");
        step(1'b0, 1'b1, "R6");
        // R1: the reset takes effect only at the edge
        rst_n = 1'b1;
        en = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b0;
        #1 check("R1", int'(c0), model[0]);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 R7: unused codes again, first held for one edge then stepped
        step(1'b0, 1'b0, "R1");
        step(1'b1, 1'b0, "R3");
        step(1'b1, 1'b1, "R4");
        step(1'b1, 1'b1, "R7");
        for (int n = 0; n < 10; n++) step(1'b1, 1'b1, "R2");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule